// File: doc/BRIEF.md
# Software Pointer-Realignment Handshake Controller

This block sits on the register side of a dual-port FIFO and turns software writes into pointer realignment requests. Each port has a small control field that software writes: a request bit and a three-bit phase offset. Setting the request bit arms the port, and the port's acknowledge bit goes high. Clearing the request bit, with the offset unchanged, releases the request. Only then is a realignment request raised toward the FIFO, carrying the port number and the latched offset.

When the FIFO returns its done pulse, three things happen on the same clock edge. The acknowledge bit of the serviced port drops. A shared sticky "aligned" event flag is set. The number of the port that finished is recorded. Software clears the event flag by writing a one to bit 2 of the event register.

An offset write that disagrees with the latched offset while a port is busy is reported as a protocol error. When several ports are released at once, the lowest-numbered port (port A) goes first.

Top module: `ptr_realign_ctrl`

## Requirements
- R1: After reset, `ack_o`, `realign_req_o`, `aligned_flag_o` and `proto_err_o` are all 0.
- R2: In a control write, bit 3 is the request and bits 2:0 are the offset. A write with the request bit at 1 to an idle port sets that port's `ack_o` bit after the same clock edge and latches the offset.
- R3: While the request bit stays at 1, `ack_o` stays at 1 and no realignment request is raised.
- R4: A write that clears the request bit with an unchanged offset raises `realign_req_o` after the second clock edge that follows the write. `realign_port_o` then shows the port and `realign_ofs_o` shows the latched offset.
- R5: A `done_i` pulse while `realign_req_o` is 1 does the following at that edge: it clears `realign_req_o` and the serviced port's `ack_o` bit, sets `aligned_flag_o`, and loads that port into `aligned_port_o`.
- R6: `aligned_flag_o` stays set until an event write with bit 2 at 1 clears it. Event writes with bit 2 at 0 leave it set. If a completion arrives in the same cycle as a clear, the flag stays set.
- R7: On a non-idle port, a control write whose offset differs from the latched offset pulses that port's `proto_err_o` for one cycle after the write. The sequence is not restarted, and the original offset is the one used for realignment.
- R8: When both ports are released in the same write cycle, port 0 is serviced first. Port 1 follows on the second edge after port 0 completes.
- R9: A `done_i` pulse while `realign_req_o` is 0 has no effect on the flag, the acknowledges or the request.
- R10: Clearing the request bit on an idle port has no effect. Setting it again on a released or in-service port has no effect and does not restart that port.
- R11: While `realign_req_o` stays high, `realign_port_o` and `realign_ofs_o` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr_i | input | NUM_PORTS | Per-port control write strobe |
| ctl_wdata_i | input | 4*NUM_PORTS | Per-port control field: bit 3 request, bits 2:0 offset |
| evt_wr_i | input | 1 | Event register write strobe |
| evt_wdata_i | input | 8 | Event write data; a 1 in bit 2 clears the aligned flag |
| done_i | input | 1 | Realignment completion pulse from the FIFO |
| ack_o | output | NUM_PORTS | Per-port acknowledge bit |
| realign_req_o | output | 1 | Realignment request toward the FIFO |
| realign_port_o | output | IDX_W | Port to be realigned |
| realign_ofs_o | output | 3 | Offset to apply |
| aligned_flag_o | output | 1 | Sticky aligned event flag |
| aligned_port_o | output | IDX_W | Port of the latest completed realignment |
| proto_err_o | output | NUM_PORTS | One-cycle protocol error pulse per port |

## Verification
Acknowledge changes, error pulses and event-flag changes are due on the first edge after the causing write or done pulse. The realignment request is due on the second edge after a release. The bench drives every input on a falling edge and samples right after the next falling edge, so each check sees exactly the edges counted above. For the realignment request, the bench first checks that it is still low one edge after the release, then checks it one edge later. Random sequences vary the port, the offset, the hold time and the done latency, and they insert bad-offset writes. Each expected value comes from the requirement rules, evaluated in bench functions.

// File: rtl/ptr_realign_pkg.sv
package ptr_realign_pkg;
    localparam int unsigned CTL_W     = 4;
    localparam int unsigned REQ_BIT   = 3;
    localparam int unsigned OFS_W     = 3;
    localparam int unsigned EVT_W     = 8;
    localparam int unsigned ALIGN_BIT = 2;

    typedef enum logic [1:0] {
        PS_IDLE   = 2'd0,
        PS_HELD   = 2'd1,
        PS_PEND   = 2'd2,
        PS_ACTIVE = 2'd3
    } port_state_e;

    typedef struct packed {
        logic             req;
        logic [OFS_W-1:0] ofs;
    } ctl_field_t;

    function automatic ctl_field_t decode_ctl(input logic [CTL_W-1:0] w);
        ctl_field_t f;
        f.req = w[REQ_BIT];
        f.ofs = w[OFS_W-1:0];
        return f;
    endfunction

    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/ptr_realign_port.sv
module ptr_realign_port
    import ptr_realign_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_hit,
    input  ctl_field_t       wr_fld,
    input  logic             grant,
    input  logic             done_hit,
    output logic             ack,
    output logic             pend,
    output logic [OFS_W-1:0] ofs_q,
    output logic             err
);
    port_state_e st;
    logic        ofs_mis;

    assign ofs_mis = (wr_fld.ofs != ofs_q);
    assign ack     = (st != PS_IDLE);
    assign pend    = (st == PS_PEND);

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= PS_IDLE;
            ofs_q <= '0;
            err   <= 1'b0;
        end else begin
            err <= wr_hit && (st != PS_IDLE) && ofs_mis;
            unique case (st)
                PS_IDLE: begin
                    if (wr_hit && wr_fld.req) begin
                        st    <= PS_HELD;
                        ofs_q <= wr_fld.ofs;
                    end
                end
                PS_HELD: begin
                    if (wr_hit && !ofs_mis && !wr_fld.req) st <= PS_PEND;
                end
                PS_PEND: begin
                    if (grant) st <= PS_ACTIVE;
                end
                PS_ACTIVE: begin
                    if (done_hit) st <= PS_IDLE;
                end
                default: st <= PS_IDLE;
            endcase
        end
    end

    // R2: acknowledge only rises after an accepted request write
    a_r2_ack_rise_on_req: assert property (@(posedge clk) disable iff (rst)
        $rose(ack) |-> $past(wr_hit && wr_fld.req));
    // R5: acknowledge only falls on completion of this port
    a_r5_ack_fall_on_done: assert property (@(posedge clk) disable iff (rst)
        $fell(ack) |-> $past(done_hit));
    // R7: an error write leaves the latched offset alone
    a_r7_err_keeps_ofs: assert property (@(posedge clk) disable iff (rst)
        err |-> (ofs_q == $past(ofs_q)));
    // R3: a held request never reaches the arbiter without a release write
    a_r3_pend_needs_release: assert property (@(posedge clk) disable iff (rst)
        $rose(pend) |-> $past(wr_hit && !wr_fld.req));
endmodule

// File: rtl/ptr_realign_arb.sv
module ptr_realign_arb #(
    parameter int unsigned NUM_PORTS = 2,
    parameter int unsigned IDX_W     = 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_PORTS-1:0] pend,
    input  logic                 done_i,
    output logic [NUM_PORTS-1:0] grant,
    output logic                 busy_q,
    output logic [IDX_W-1:0]     cur_q,
    output logic                 done_ok
);
    logic             found;
    logic [IDX_W-1:0] sel;

    always_comb begin
        grant = '0;
        found = 1'b0;
        sel   = '0;
        for (int i = 0; i < NUM_PORTS; i++) begin
            if (!busy_q && pend[i] && !found) begin
                grant[i] = 1'b1;
                found    = 1'b1;
                sel      = IDX_W'(i);
            end
        end
    end

    assign done_ok = done_i && busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cur_q  <= '0;
        end else if (done_ok) begin
            busy_q <= 1'b0;
        end else if (found) begin
            busy_q <= 1'b1;
            cur_q  <= sel;
        end
    end

    // R8: at most one port is started at a time
    a_r8_grant_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));
    // R11: the serviced port is held for the whole service
    a_r11_port_held: assert property (@(posedge clk) disable iff (rst)
        (busy_q && $past(busy_q)) |-> $stable(cur_q));
endmodule

// File: rtl/ptr_realign_evt.sv
module ptr_realign_evt #(
    parameter int unsigned IDX_W = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             done_ok,
    input  logic [IDX_W-1:0] cur,
    input  logic             clr_hit,
    output logic             flag,
    output logic [IDX_W-1:0] port_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag   <= 1'b0;
            port_q <= '0;
        end else if (done_ok) begin
            flag   <= 1'b1;
            port_q <= cur;
        end else if (clr_hit) begin
            flag <= 1'b0;
        end
    end

    // R6: completion always leaves the flag set, even against a clear
    a_r6_set_wins: assert property (@(posedge clk) disable iff (rst)
        $past(done_ok) |-> flag);
    // R6: the flag only drops through a clearing write
    a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
        $fell(flag) |-> $past(clr_hit));
endmodule

// File: rtl/ptr_realign_ctrl.sv
module ptr_realign_ctrl
    import ptr_realign_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 2,
    localparam int unsigned IDX_W    = idx_width(NUM_PORTS)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_PORTS-1:0]       ctl_wr_i,
    input  logic [NUM_PORTS*CTL_W-1:0] ctl_wdata_i,
    input  logic                       evt_wr_i,
    input  logic [EVT_W-1:0]           evt_wdata_i,
    input  logic                       done_i,
    output logic [NUM_PORTS-1:0]       ack_o,
    output logic                       realign_req_o,
    output logic [IDX_W-1:0]           realign_port_o,
    output logic [OFS_W-1:0]           realign_ofs_o,
    output logic                       aligned_flag_o,
    output logic [IDX_W-1:0]           aligned_port_o,
    output logic [NUM_PORTS-1:0]       proto_err_o
);
    logic [NUM_PORTS-1:0] pend;
    logic [NUM_PORTS-1:0] grant;
    logic                 busy_q;
    logic [IDX_W-1:0]     cur_q;
    logic                 done_ok;
    logic [OFS_W-1:0]     ofs_q [NUM_PORTS];

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
        ptr_realign_port u_port (
            .clk      (clk),
            .rst      (rst),
            .wr_hit   (ctl_wr_i[g]),
            .wr_fld   (decode_ctl(ctl_wdata_i[g*CTL_W +: CTL_W])),
            .grant    (grant[g]),
            .done_hit (done_ok && (cur_q == IDX_W'(g))),
            .ack      (ack_o[g]),
            .pend     (pend[g]),
            .ofs_q    (ofs_q[g]),
            .err      (proto_err_o[g])
        );
    end

    ptr_realign_arb #(
        .NUM_PORTS (NUM_PORTS),
        .IDX_W     (IDX_W)
    ) u_arb (
        .clk     (clk),
        .rst     (rst),
        .pend    (pend),
        .done_i  (done_i),
        .grant   (grant),
        .busy_q  (busy_q),
        .cur_q   (cur_q),
        .done_ok (done_ok)
    );

    ptr_realign_evt #(
        .IDX_W (IDX_W)
    ) u_evt (
        .clk     (clk),
        .rst     (rst),
        .done_ok (done_ok),
        .cur     (cur_q),
        .clr_hit (evt_wr_i && evt_wdata_i[ALIGN_BIT]),
        .flag    (aligned_flag_o),
        .port_q  (aligned_port_o)
    );

    assign realign_req_o  = busy_q;
    assign realign_port_o = cur_q;
    assign realign_ofs_o  = ofs_q[cur_q];

    // R8: when port 0 was waiting, a new service starts with port 0
    a_r8_port_a_first: assert property (@(posedge clk) disable iff (rst)
        ($rose(realign_req_o) && $past(pend[0])) |-> (realign_port_o == '0));
    // R11: offset presented to the FIFO is steady during service
    a_r11_ofs_steady: assert property (@(posedge clk) disable iff (rst)
        (realign_req_o && $past(realign_req_o)) |-> $stable(realign_ofs_o));
    // R9: a stray done pulse raises no event
    a_r9_stray_done: assert property (@(posedge clk) disable iff (rst)
        (done_i && !realign_req_o) |=> !$rose(aligned_flag_o));
endmodule

// File: tb/ptr_realign_ctrl_tb.sv
module ptr_realign_ctrl_tb_top;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] ctl_wr;
    logic [7:0] ctl_wdata;
    logic       evt_wr;
    logic [7:0] evt_wdata;
    logic       done;
    logic [1:0] ack;
    logic       req;
    logic       req_port;
    logic [2:0] req_ofs;
    logic       flag;
    logic       flag_port;
    logic [1:0] err;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    ptr_realign_ctrl dut_i (
        .clk            (clk),
        .rst            (rst),
        .ctl_wr_i       (ctl_wr),
        .ctl_wdata_i    (ctl_wdata),
        .evt_wr_i       (evt_wr),
        .evt_wdata_i    (evt_wdata),
        .done_i         (done),
        .ack_o          (ack),
        .realign_req_o  (req),
        .realign_port_o (req_port),
        .realign_ofs_o  (req_ofs),
        .aligned_flag_o (flag),
        .aligned_port_o (flag_port),
        .proto_err_o    (err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    // expected flag after an event write: bit 2 set clears it
    function automatic bit exp_flag_after_clr(input bit cur, input logic [7:0] d);
        return d[2] ? 1'b0 : cur;
    endfunction

    // expected error pulse: offset differs from the latched one
    function automatic bit exp_err(input logic [2:0] held, input logic [2:0] wr);
        return held != wr;
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input int p, input bit rq, input logic [2:0] o);
        ctl_wr[p] = 1'b1;
        ctl_wdata[p*4 +: 4] = {rq, o};
        step();
        ctl_wr = '0;
    endtask

    task automatic pulse_done();
        done = 1'b1;
        step();
        done = 1'b0;
    endtask

    task automatic evt_write(input logic [7:0] d);
        evt_wr = 1'b1;
        evt_wdata = d;
        step();
        evt_wr = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; ctl_wr = '0; ctl_wdata = '0;
        evt_wr = 1'b0; evt_wdata = '0; done = 1'b0;
        @(negedge clk);
        step(); step();
        rst = 1'b0;
        step();
        chk("R1 ack", ack, 0);
        chk("R1 req", req, 0);
        chk("R1 flag", flag, 0);
        chk("R1 err", err, 0);

        // R9: stray done
        pulse_done();
        chk("R9 flag", flag, 0);
        chk("R9 req", req, 0);

        // R10: clear on idle port
        wr(0, 1'b0, 3'd2);
        chk("R10 idle clear ack", ack, 0);
        step();
        chk("R10 idle clear req", req, 0);

        // directed sequence port 1, offset 6
        wr(1, 1'b1, 3'd6);
        chk("R2 ack", ack, 2);
        repeat (3) step();
        chk("R3 ack held", ack, 2);
        chk("R3 no req", req, 0);
        wr(1, 1'b0, 3'd6);
        chk("R4 not yet", req, 0);
        step();
        chk("R4 req", req, 1);
        chk("R4 port", req_port, 1);
        chk("R4 ofs", req_ofs, 6);
        wr(1, 1'b1, 3'd6);
        chk("R10 no restart ack", ack, 2);
        chk("R10 no restart req", req, 1);
        step();
        chk("R11 ofs", req_ofs, 6);
        pulse_done();
        chk("R5 ack", ack, 0);
        chk("R5 flag", flag, 1);
        chk("R5 port", flag_port, 1);
        chk("R5 req", req, 0);

        // R6 sticky
        evt_write(8'hFB);
        chk("R6 no clear", flag, 1);
        evt_write(8'h04);
        chk("R6 clear", flag, 0);

        // R8 priority + R6 set wins
        ctl_wr = 2'b11; ctl_wdata = {4'b1101, 4'b1011};
        step(); ctl_wr = '0;
        chk("R8 both ack", ack, 3);
        ctl_wr = 2'b11; ctl_wdata = {4'b0101, 4'b0011};
        step(); ctl_wr = '0;
        step();
        chk("R8 first req", req, 1);
        chk("R8 first port", req_port, 0);
        chk("R8 first ofs", req_ofs, 3);
        done = 1'b1; evt_wr = 1'b1; evt_wdata = 8'h04;
        step();
        done = 1'b0; evt_wr = 1'b0;
        chk("R6 set wins", flag, 1);
        chk("R8 port0 done", flag_port, 0);
        chk("R8 ack left", ack, 2);
        chk("R8 gap", req, 0);
        step();
        chk("R8 second port", req_port, 1);
        chk("R8 second req", req, 1);
        chk("R8 second ofs", req_ofs, 5);
        pulse_done();
        chk("R8 port1 done", flag_port, 1);
        evt_write(8'h04);

        // randomised sequences
        for (int it = 0; it < 40; it++) begin
            int p = $urandom % 2;
            logic [2:0] o = 3'($urandom % 8);
            bit f;
            wr(p, 1'b1, o);
            chk("R2 rnd ack", ack[p], 1);
            if ($urandom % 3 == 0) begin
                logic [2:0] bad = o ^ 3'(1 + $urandom % 7);
                wr(p, 1'($urandom % 2), bad);
                chk("R7 err", err[p], exp_err(o, bad));
                chk("R7 ack kept", ack[p], 1);
                step();
                chk("R7 pulse ends", err[p], 0);
            end
            repeat ($urandom % 4) step();
            chk("R3 rnd no req", req, 0);
            wr(p, 1'b0, o);
            chk("R7 no err", err[p], 0);
            step();
            chk("R4 rnd req", req, 1);
            chk("R4 rnd port", req_port, p);
            chk("R4 rnd ofs", req_ofs, o);
            repeat ($urandom % 5) step();
            chk("R11 rnd ofs", req_ofs, o);
            pulse_done();
            chk("R5 rnd ack", ack[p], 0);
            chk("R5 rnd flag", flag, 1);
            chk("R5 rnd port", flag_port, p);
            f = flag;
            begin
                logic [7:0] d = 8'($urandom);
                evt_write(d);
                chk("R6 rnd clr", flag, exp_flag_after_clr(f, d));
            end
            evt_write(8'h04);
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule